// File: doc/BRIEF.md
# ADC Convert-and-Read Sequencer

This block is the host-side controller for a sampling converter that has a 16-bit parallel result bus, an active-low chip-select line, a convert/read select line (low requests a conversion, high enables a read) and an active-low busy indication. A single-cycle start request causes the sequencer to do several things in turn. It first pulls chip-select low. After a short lead time it pulls the convert line low for a bounded pulse. It then releases both lines and waits for busy to drop and come back. Finally it enables the bus for a read window and captures the word.

The captured word is a two's-complement sample. It is presented on a signed output together with a one-cycle valid strobe. If busy does not complete its low-then-high cycle within a set number of clocks, the sequencer raises a one-cycle timeout flag and returns to idle. A new conversion is held off until a minimum spacing has passed since the previous convert pulse began, so that the converter can acquire a fresh signal. Start requests that cannot be taken are dropped, not queued.

Every timing value is given in nanoseconds and converted to clock cycles at elaboration. The elaboration checks compare the pulse against the 40 ns to 6 µs window, the lead against 10 ns and the spacing against 10 µs. With the defaults (4 ns clock) the lead is 5 cycles, the pulse is 25, the read window is 10, the spacing is 2500 and the timeout is 3000.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset and whenever idle, chip-select and the convert line are both high (1), the valid strobe and the timeout flag are 0.
- R2: A start sampled while idle (and spacing elapsed) drives chip-select low with the convert line high for LEAD_CYC cycles. Both lines are then low for exactly PULSE_CYC cycles, and PULSE_CYC lies between 40 ns and 6 µs of clock time.
- R3: When the convert pulse ends, both lines go high together and stay high while busy is awaited, so that busy never returns high while both lines are low.
- R4: Busy passes through SYNC_STAGES flops. SYNC_STAGES+1 cycles after busy returns high, chip-select goes low with the convert line high for READ_CYC cycles. The bus is captured on the last of these cycles, and the valid strobe is high for the single cycle that follows, with both lines high again.
- R5: The captured word is 16-bit two's complement with bit 15 as the sign/MSB. It appears unchanged on the signed sample output and holds until the next capture.
- R6: If busy has not both fallen and risen within TIMEOUT_CYC cycles after the pulse ends, the timeout flag is high for one cycle, TIMEOUT_CYC cycles after the first released cycle. No valid strobe is produced and the sequencer returns to idle.
- R7: A start is taken only at a clock edge at least SPACE_CYC edges after the first cycle of the previous convert pulse. A start one edge earlier is dropped.
- R8: Start requests that arrive during a sequence or inside the spacing interval are dropped and leave the control lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion and read |
| adc_busy_n_i | input | 1 | Converter busy, low while converting (asynchronous) |
| adc_data_i | input | DATA_W | Converter parallel result bus |
| adc_cs_n_o | output | 1 | Active-low chip-select to converter |
| adc_cnv_n_o | output | 1 | Low requests conversion, high selects read |
| sample_o | output | DATA_W | Captured signed sample |
| sample_vld_o | output | 1 | One-cycle strobe, new sample present |
| timeout_o | output | 1 | One-cycle strobe, busy handshake timed out |

## Verification
The assertions check on every cycle the following properties: the convert pulse stays inside its minimum and maximum width; chip-select is already low before the convert line falls; at least one line is high whenever synchronised busy rises; convert pulses are spaced by at least the acquisition interval; and a valid strobe lasts one cycle and directly follows a read window. Only the bench scenarios can show the rest. These are the exact cycle positions of each phase against a timeline, the captured values including the extreme positive and negative codes, and the one-edge boundary at which a start is dropped or taken. They also cover starts held through a whole sequence, and the timeout timing for a converter that never starts and for one that never finishes.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LEAD,
      S_PULSE,
      S_WFALL,
      S_WRISE,
      S_READ
   } seq_state_t;

   // converter timing limits in picoseconds
   localparam int unsigned CNV_MIN_PS   = 40_000;
   localparam int unsigned CNV_MAX_PS   = 6_000_000;
   localparam int unsigned LEAD_MIN_PS  = 10_000;
   localparam int unsigned SPACE_MIN_PS = 10_000_000;

   // round a nanosecond duration up to whole clock cycles
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   initial begin
      assert (STAGES >= 2) else $error("adcseq_sync: STAGES must be at least 2");
   end

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RESET_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);

   // a loaded count never jumps upward on its own
   assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && $past(cnt) == '0) |-> cnt == '0);

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
   import adcseq_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CLK_PS      = 4000,
   parameter int unsigned LEAD_NS     = 20,
   parameter int unsigned PULSE_NS    = 100,
   parameter int unsigned READ_NS     = 40,
   parameter int unsigned SPACE_NS    = 10_000,
   parameter int unsigned TIMEOUT_CYC = 3000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     adc_busy_n_i,
   input  logic [DATA_W-1:0]        adc_data_i,
   output logic                     adc_cs_n_o,
   output logic                     adc_cnv_n_o,
   output logic signed [DATA_W-1:0] sample_o,
   output logic                     sample_vld_o,
   output logic                     timeout_o
);

   localparam int unsigned LEAD_CYC      = ns_to_cyc(LEAD_NS, CLK_PS);
   localparam int unsigned PULSE_CYC     = ns_to_cyc(PULSE_NS, CLK_PS);
   localparam int unsigned READ_CYC      = ns_to_cyc(READ_NS, CLK_PS);
   localparam int unsigned SPACE_CYC     = ns_to_cyc(SPACE_NS, CLK_PS);
   localparam int unsigned PULSE_MIN_CYC = (CNV_MIN_PS + CLK_PS - 1) / CLK_PS;
   localparam int unsigned PULSE_MAX_CYC = CNV_MAX_PS / CLK_PS;
   localparam int unsigned PH_A   = (LEAD_CYC > PULSE_CYC) ? LEAD_CYC : PULSE_CYC;
   localparam int unsigned PH_B   = (READ_CYC > TIMEOUT_CYC) ? READ_CYC : TIMEOUT_CYC;
   localparam int unsigned PH_MAX = (PH_A > PH_B) ? PH_A : PH_B;
   localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
   localparam int unsigned SP_W   = $clog2(SPACE_CYC + 1);
   localparam int unsigned LR_W   = $clog2(PULSE_MAX_CYC + 2);

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W too small");
      assert (LEAD_CYC >= 1 && LEAD_CYC * CLK_PS >= LEAD_MIN_PS) else $error("lead below 10 ns");
      assert (PULSE_CYC >= PULSE_MIN_CYC) else $error("convert pulse below 40 ns");
      assert (PULSE_CYC <= PULSE_MAX_CYC) else $error("convert pulse above 6 us");
      assert (SPACE_CYC * CLK_PS >= SPACE_MIN_PS) else $error("spacing below 10 us");
      assert (READ_CYC >= 1) else $error("read window empty");
      assert (TIMEOUT_CYC >= 2) else $error("timeout too short");
   end

   seq_state_t       st, nxt;
   logic             busy_s_n;
   logic             ph_load, ph_zero, sp_load, sp_zero;
   logic [PH_W-1:0]  ph_val;
   logic             cap, to_hit;

   adcseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_busy_sync (
      .clk(clk), .rst_n(rst_n), .d(adc_busy_n_i), .q(busy_s_n)
   );

   adcseq_timer #(.W(PH_W)) i_phase_timer (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
   );

   adcseq_timer #(.W(SP_W)) i_space_timer (
      .clk(clk), .rst_n(rst_n), .load(sp_load), .load_val(SP_W'(SPACE_CYC - 1)), .zero(sp_zero)
   );

   always_comb begin
      nxt     = st;
      ph_load = 1'b0;
      ph_val  = '0;
      sp_load = 1'b0;
      cap     = 1'b0;
      to_hit  = 1'b0;
      case (st)
         S_IDLE: if (start_i && sp_zero) begin
            nxt = S_LEAD; ph_load = 1'b1; ph_val = PH_W'(LEAD_CYC - 1);
         end
         S_LEAD: if (ph_zero) begin
            nxt = S_PULSE; ph_load = 1'b1; ph_val = PH_W'(PULSE_CYC - 1); sp_load = 1'b1;
         end
         S_PULSE: if (ph_zero) begin
            nxt = S_WFALL; ph_load = 1'b1; ph_val = PH_W'(TIMEOUT_CYC - 1);
         end
         S_WFALL: begin
            if (ph_zero)        begin nxt = S_IDLE; to_hit = 1'b1; end
            else if (!busy_s_n) nxt = S_WRISE;
         end
         S_WRISE: begin
            if (ph_zero)       begin nxt = S_IDLE; to_hit = 1'b1; end
            else if (busy_s_n) begin nxt = S_READ; ph_load = 1'b1; ph_val = PH_W'(READ_CYC - 1); end
         end
         S_READ: if (ph_zero) begin
            nxt = S_IDLE; cap = 1'b1;
         end
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= S_IDLE;
         sample_o     <= '0;
         sample_vld_o <= 1'b0;
         timeout_o    <= 1'b0;
      end else begin
         st           <= nxt;
         sample_vld_o <= cap;
         timeout_o    <= to_hit;
         if (cap) sample_o <= $signed(adc_data_i);
      end
   end

   assign adc_cs_n_o  = !(st inside {S_LEAD, S_PULSE, S_READ});
   assign adc_cnv_n_o = (st != S_PULSE);

   // ---------------- checker state and assertions ----------------
   logic            both_low, both_low_q;
   logic [LR_W-1:0] low_run;
   logic [SP_W-1:0] gap;

   assign both_low = !adc_cs_n_o && !adc_cnv_n_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         both_low_q <= 1'b0;
         low_run    <= '0;
         gap        <= SP_W'(SPACE_CYC);
      end else begin
         both_low_q <= both_low;
         if (!both_low)                             low_run <= '0;
         else if (low_run != LR_W'(PULSE_MAX_CYC + 1)) low_run <= low_run + LR_W'(1);
         if (both_low && !both_low_q)               gap <= SP_W'(1);
         else if (gap != SP_W'(SPACE_CYC))          gap <= gap + SP_W'(1);
      end
   end

   assert_pulse_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
      both_low |-> low_run < LR_W'(PULSE_MAX_CYC));

   assert_pulse_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!both_low && both_low_q) |-> low_run >= LR_W'(PULSE_MIN_CYC));

   assert_cs_leads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cnv_n_o) |-> !$past(adc_cs_n_o));

   assert_released_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_s_n) |-> (adc_cs_n_o || adc_cnv_n_o));

   assert_single_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld_o |=> !sample_vld_o);

   assert_read_before_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld_o |-> ($past(!adc_cs_n_o && adc_cnv_n_o) && adc_cs_n_o && adc_cnv_n_o));

   assert_timeout_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (!sample_vld_o && $past(adc_cs_n_o && adc_cnv_n_o)));

   assert_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (both_low && !both_low_q) |-> gap >= SP_W'(SPACE_CYC));

endmodule

// File: tb/test_adc_conv_sequencer.sv
module test_adc_conv_sequencer;

   // expected cycle counts for a 4 ns clock, worked out by hand:
   // 20 ns -> 5, 100 ns -> 25, 40 ns -> 10, 10 us -> 2500
   localparam int LEAD    = 5;
   localparam int PULSE   = 25;
   localparam int READ    = 10;
   localparam int SPACE   = 2500;
   localparam int TIMEOUT = 3000;
   localparam int SYNC    = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy_n = 1'b1;
   logic [15:0] bus;
   logic        cs_n, cnv_n, vld, to;
   logic signed [15:0] smp;

   int    checks = 0, fails = 0, cyc = 0;
   string req = "R1";
   logic  e_cs = 1'b1, e_cnv = 1'b1, e_vld = 1'b0, e_to = 1'b0;
   logic [15:0] e_smp = '0;

   // converter model state
   int          adc_mode = 0;  // 0 normal, 1 never starts, 2 never finishes
   bit          adc_conv = 1'b0;
   int          adc_left = 0, conv_len = 100;
   logic [15:0] adc_word = 16'h0000, adc_next = 16'h0000;
   bit          rose = 1'b0;

   always #2ns clk = ~clk;

   assign bus = (!cs_n && cnv_n) ? adc_word : 16'h5A5A;

   adc_conv_sequencer #(
      .DATA_W(16), .CLK_PS(4000), .LEAD_NS(20), .PULSE_NS(100), .READ_NS(40),
      .SPACE_NS(10_000), .TIMEOUT_CYC(TIMEOUT), .SYNC_STAGES(SYNC)
   ) i_adc_conv_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start), .adc_busy_n_i(busy_n),
      .adc_data_i(bus), .adc_cs_n_o(cs_n), .adc_cnv_n_o(cnv_n),
      .sample_o(smp), .sample_vld_o(vld), .timeout_o(to)
   );

   task automatic expect_lines(input logic cs, input logic cnv);
      e_cs = cs; e_cnv = cnv; e_vld = 1'b0; e_to = 1'b0;
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
      checks++;
      if (cs_n !== e_cs || cnv_n !== e_cnv || vld !== e_vld || to !== e_to ||
          (e_vld && smp !== e_smp)) begin
         fails++;
         $display("FAIL %s cycle %0d: cs_n/cnv_n/vld/timeout/sample = %b%b%b%b/%h expected %b%b%b%b/%h",
                  req, cyc, cs_n, cnv_n, vld, to, smp, e_cs, e_cnv, e_vld, e_to, e_smp);
      end
      // converter model reacts after the outputs are compared
      if (!adc_conv) begin
         if (adc_mode != 1 && !cs_n && !cnv_n) begin
            adc_conv = 1'b1; busy_n = 1'b0; adc_left = conv_len;
         end
      end else if (adc_mode == 0) begin
         adc_left--;
         if (adc_left == 0) begin
            adc_conv = 1'b0; busy_n = 1'b1; adc_word = adc_next; rose = 1'b1;
         end
      end
   endtask

   // start must be accepted: expects a full convert-and-read sequence
   task automatic run_conv(input logic [15:0] val, input int conv, input bit hold, output int q);
      int n;
      adc_next = val; conv_len = conv;
      req = "R2"; start = 1'b1; expect_lines(1'b0, 1'b1);
      for (int i = 0; i < LEAD; i++) begin
         step();
         if (!hold) start = 1'b0;
      end
      q = cyc + 1;
      expect_lines(1'b0, 1'b0);
      repeat (PULSE) step();
      req = hold ? "R8" : "R3";
      expect_lines(1'b1, 1'b1);
      rose = 1'b0; n = 0;
      while (!rose && n < TIMEOUT) begin
         step(); n++;
         if (n == 20) start = 1'b0;
      end
      if (!rose) begin
         fails++; $display("FAIL R4: converter model never finished, got 0 expected 1");
      end
      repeat (SYNC) step();
      start = 1'b0;
      req = "R4"; expect_lines(1'b0, 1'b1);
      repeat (READ) step();
      req = "R5"; expect_lines(1'b1, 1'b1); e_vld = 1'b1; e_smp = val;
      step();
      req = "R1"; e_vld = 1'b0;
      step();
   endtask

   task automatic run_fault(input int mode, output int q);
      adc_mode = mode;
      req = "R2"; start = 1'b1; expect_lines(1'b0, 1'b1);
      for (int i = 0; i < LEAD; i++) begin step(); start = 1'b0; end
      q = cyc + 1;
      expect_lines(1'b0, 1'b0);
      repeat (PULSE) step();
      req = "R6"; expect_lines(1'b1, 1'b1);
      repeat (TIMEOUT) step();
      e_to = 1'b1; step();
      e_to = 1'b0; step();
      adc_mode = 0; adc_conv = 1'b0; busy_n = 1'b1;
   endtask

   task automatic wait_space(input int q);
      req = "R7"; expect_lines(1'b1, 1'b1);
      while (cyc < q + SPACE - 1) step();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run still going, got 200000 cycles expected fewer");
      summary();
      $finish;
   end

   initial begin
      int q;
      expect_lines(1'b1, 1'b1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      req = "R1";
      repeat (4) step();

      // largest positive code
      run_conv(16'h7FFF, 200, 1'b0, q);

      // R7 boundary: one edge early is dropped, next edge is taken
      req = "R7"; expect_lines(1'b1, 1'b1);
      while (cyc < q + SPACE - 2) step();
      start = 1'b1;
      step();
      // R8: start held high through the whole sequence, most negative code
      run_conv(16'h8000, 300, 1'b1, q);
      checks++;
      if (smp >= 0) begin
         fails++; $display("FAIL R5: sample sign got %0d expected negative", smp);
      end

      // converter that never starts
      wait_space(q);
      run_fault(1, q);
      // converter that never finishes
      wait_space(q);
      run_fault(2, q);

      // normal operation resumes after faults
      wait_space(q);
      run_conv(16'hFFFE, 150, 1'b0, q);
      checks++;
      if (smp != -2) begin
         fails++; $display("FAIL R5: sample got %0d expected -2", smp);
      end
      req = "R1"; expect_lines(1'b1, 1'b1);
      repeat (5) step();

      summary();
      $finish;
   end

endmodule